// File: doc/BRIEF.md
# Register Rename Map with Slot Allocator

This block is the rename stage of an out-of-order core. It keeps one map entry per architectural register. Each entry says where the newest value of that register lives. The value is either in the committed architectural file, or it is still in flight in a reorder-buffer slot. Every cycle a group of up to `GROUP` micro-operations arrives. Each one names two source registers and one destination register. The block returns the current location of every source. It also hands each valid destination a fresh slot, taken in order from the slot base that the reorder buffer supplies. At the next clock edge the block records the new producers in the map.

A source that names the destination of a lower-numbered valid lane in the same group takes that lane's new slot, not the stale map entry. When the reorder buffer retires a slot, it reports the slot and its register. The map falls back to the committed file only if it still points at that exact slot. A flush drops all in-flight mappings at once.

Top module: `rnm_rename`

## Requirements
- R1: While reset is held and right after it, every register maps to the committed file: a lookup returns flag 0 and an index equal to the register number.
- R2: Each source lookup returns a flag (1 = reorder slot, 0 = committed file) and a 6-bit index (slot number or register number). It reflects the map as it stood at the start of the cycle; that cycle's own writes, clears and flush show only from the next cycle.
- R3: Valid lanes get slots in lane order. A lane's slot is the base plus the number of valid lanes below it, wrapping modulo NUM_PHYS (slot 39 is followed by slot 0). Two valid lanes never get the same slot.
- R4: At the clock edge each valid lane's destination maps to that lane's slot. If several valid lanes write one register, the highest such lane wins. A single-lane group followed by a reader of its destination sees the new slot.
- R5: A source of lane i that equals the destination of a valid lane j < i takes lane j's slot with flag 1. Among several such lanes, the highest j is used.
- R6: A retire of slot k for register r clears r to the committed file only when r currently maps to reorder slot k. Otherwise r's mapping is unchanged.
- R7: When a rename writes register r in the same cycle as a retire that would clear r, the rename wins.
- R8: A flush returns every register to the committed file. Renames presented in the flush cycle still get slots and lookups, but they do not change the map.
- R9: Invalid lanes consume no slot, write no mapping and supply no bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Drop all in-flight mappings |
| grp_vld_i | input | GROUP | Per-lane valid |
| grp_src_a_i | input | GROUP x AW | First source register per lane |
| grp_src_b_i | input | GROUP x AW | Second source register per lane |
| grp_dst_i | input | GROUP x AW | Destination register per lane |
| slot_base_i | input | PW | First free reorder slot |
| ret_vld_i | input | RET_PORTS | Retire report valid |
| ret_reg_i | input | RET_PORTS x AW | Register of the retiring slot |
| ret_slot_i | input | RET_PORTS x PW | Retiring slot number |
| src_a_rob_o | output | GROUP | First source lives in a reorder slot |
| src_a_idx_o | output | GROUP x PW | First source slot or register number |
| src_b_rob_o | output | GROUP | Second source lives in a reorder slot |
| src_b_idx_o | output | GROUP x PW | Second source slot or register number |
| dst_slot_o | output | GROUP x PW | Slot given to each lane's destination |

## Verification
Some properties are checked on every cycle:
- the base slot goes to lane 0;
- slots stay in range and the first two lanes get distinct slots;
- the intra-group bypass from lane 0 to lane 1;
- a reader right after a single-lane group sees the new producer;
- lane 0 reads the committed file right after a flush.

Other behaviour depends on history, so only the bench's sequences can show it:
- the conditional clear on retire, both when it matches and when the slot is stale;
- the priority of a rename over a retire on the same register;
- the highest lane winning a shared destination;
- slot wrap-around;
- invalid lanes leaving the map and the slot count untouched.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
   // where the newest value of a register sits
   typedef enum logic {
      LOC_ARCH = 1'b0,
      LOC_ROB  = 1'b1
   } loc_e;
endpackage

// File: rtl/rnm_slot_alloc.sv
module rnm_slot_alloc #(
   parameter int GROUP    = 4,
   parameter int NUM_PHYS = 40,
   parameter int PW       = 6
) (
   input  logic [GROUP-1:0]         vld_i,
   input  logic [PW-1:0]            base_i,
   output logic [GROUP-1:0][PW-1:0] slot_o
);
   localparam int CW = $clog2(GROUP + 1);
   localparam int SW = PW + 1;

   // prefix count of valid lanes, offset from the base, wrapped once
   always_comb begin
      logic [CW-1:0] seen;
      logic [SW-1:0] sum;
      seen = '0;
      for (int i = 0; i < GROUP; i++) begin
         sum = {1'b0, base_i} + SW'(seen);
         if (sum >= SW'(NUM_PHYS)) begin
            sum = sum - SW'(NUM_PHYS);
         end
         slot_o[i] = sum[PW-1:0];
         if (vld_i[i]) begin
            seen = seen + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rnm_lookup.sv
module rnm_lookup
   import rnm_pkg::*;
#(
   parameter int NUM_ARCH = 8,
   parameter int GROUP    = 4,
   parameter int AW       = 3,
   parameter int PW       = 6
) (
   input  logic [NUM_ARCH-1:0]         map_rob_i,
   input  logic [NUM_ARCH-1:0][PW-1:0] map_idx_i,
   input  logic [GROUP-1:0]            vld_i,
   input  logic [GROUP-1:0][AW-1:0]    src_a_i,
   input  logic [GROUP-1:0][AW-1:0]    src_b_i,
   input  logic [GROUP-1:0][AW-1:0]    dst_i,
   input  logic [GROUP-1:0][PW-1:0]    slot_i,
   output logic [GROUP-1:0]            src_a_rob_o,
   output logic [GROUP-1:0][PW-1:0]    src_a_idx_o,
   output logic [GROUP-1:0]            src_b_rob_o,
   output logic [GROUP-1:0][PW-1:0]    src_b_idx_o
);
   // the top lane never feeds a bypass
   logic unused_top_lane;
   assign unused_top_lane = ^{vld_i[GROUP-1], dst_i[GROUP-1], slot_i[GROUP-1]};

   always_comb begin
      loc_e          a_loc, b_loc;
      logic [PW-1:0] a_idx, b_idx;
      for (int i = 0; i < GROUP; i++) begin
         a_loc = loc_e'(map_rob_i[src_a_i[i]]);
         a_idx = (a_loc == LOC_ROB) ? map_idx_i[src_a_i[i]] : PW'(src_a_i[i]);
         b_loc = loc_e'(map_rob_i[src_b_i[i]]);
         b_idx = (b_loc == LOC_ROB) ? map_idx_i[src_b_i[i]] : PW'(src_b_i[i]);
         // later lower lanes override earlier ones: youngest producer wins
         for (int j = 0; j < i; j++) begin
            if (vld_i[j] && (dst_i[j] == src_a_i[i])) begin
               a_loc = LOC_ROB;
               a_idx = slot_i[j];
            end
            if (vld_i[j] && (dst_i[j] == src_b_i[i])) begin
               b_loc = LOC_ROB;
               b_idx = slot_i[j];
            end
         end
         src_a_rob_o[i] = (a_loc == LOC_ROB);
         src_a_idx_o[i] = a_idx;
         src_b_rob_o[i] = (b_loc == LOC_ROB);
         src_b_idx_o[i] = b_idx;
      end
   end
endmodule

// File: rtl/rnm_map.sv
module rnm_map #(
   parameter int NUM_ARCH  = 8,
   parameter int GROUP     = 4,
   parameter int RET_PORTS = 2,
   parameter int AW        = 3,
   parameter int PW        = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush_i,
   input  logic [GROUP-1:0]             vld_i,
   input  logic [GROUP-1:0][AW-1:0]     dst_i,
   input  logic [GROUP-1:0][PW-1:0]     slot_i,
   input  logic [RET_PORTS-1:0]         ret_vld_i,
   input  logic [RET_PORTS-1:0][AW-1:0] ret_reg_i,
   input  logic [RET_PORTS-1:0][PW-1:0] ret_slot_i,
   output logic [NUM_ARCH-1:0]          map_rob_o,
   output logic [NUM_ARCH-1:0][PW-1:0]  map_idx_o
);
   logic [NUM_ARCH-1:0]         rob_q, rob_d;
   logic [NUM_ARCH-1:0][PW-1:0] idx_q, idx_d;

   // order of the steps sets priority: retire clear, then renames, then flush
   always_comb begin
      rob_d = rob_q;
      idx_d = idx_q;
      for (int p = 0; p < RET_PORTS; p++) begin
         if (ret_vld_i[p] && rob_q[ret_reg_i[p]] &&
             (idx_q[ret_reg_i[p]] == ret_slot_i[p])) begin
            rob_d[ret_reg_i[p]] = 1'b0;
         end
      end
      for (int i = 0; i < GROUP; i++) begin
         if (vld_i[i]) begin
            rob_d[dst_i[i]] = 1'b1;
            idx_d[dst_i[i]] = slot_i[i];
         end
      end
      if (flush_i) begin
         rob_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rob_q <= '0;
         idx_q <= '0;
      end else begin
         rob_q <= rob_d;
         idx_q <= idx_d;
      end
   end

   assign map_rob_o = rob_q;
   assign map_idx_o = idx_q;
endmodule

// File: rtl/rnm_rename.sv
module rnm_rename #(
   parameter int  NUM_ARCH  = 8,
   parameter int  NUM_PHYS  = 40,
   parameter int  GROUP     = 4,
   parameter int  RET_PORTS = 2,
   localparam int AW        = $clog2(NUM_ARCH),
   localparam int PW        = $clog2(NUM_PHYS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush_i,
   input  logic [GROUP-1:0]             grp_vld_i,
   input  logic [GROUP-1:0][AW-1:0]     grp_src_a_i,
   input  logic [GROUP-1:0][AW-1:0]     grp_src_b_i,
   input  logic [GROUP-1:0][AW-1:0]     grp_dst_i,
   input  logic [PW-1:0]                slot_base_i,
   input  logic [RET_PORTS-1:0]         ret_vld_i,
   input  logic [RET_PORTS-1:0][AW-1:0] ret_reg_i,
   input  logic [RET_PORTS-1:0][PW-1:0] ret_slot_i,
   output logic [GROUP-1:0]             src_a_rob_o,
   output logic [GROUP-1:0][PW-1:0]     src_a_idx_o,
   output logic [GROUP-1:0]             src_b_rob_o,
   output logic [GROUP-1:0][PW-1:0]     src_b_idx_o,
   output logic [GROUP-1:0][PW-1:0]     dst_slot_o
);
   // elaboration-time parameter checks
   if (NUM_ARCH < 2 || (1 << AW) != NUM_ARCH) begin : g_bad_arch
      $error("NUM_ARCH must be a power of two of at least 2");
   end
   if (NUM_PHYS < NUM_ARCH) begin : g_bad_phys
      $error("NUM_PHYS must cover every register number");
   end
   if (GROUP < 1 || GROUP > NUM_PHYS) begin : g_bad_group
      $error("GROUP must lie in 1..NUM_PHYS");
   end
   if (RET_PORTS < 1) begin : g_bad_ret
      $error("RET_PORTS must be at least 1");
   end

   logic [NUM_ARCH-1:0]         map_rob;
   logic [NUM_ARCH-1:0][PW-1:0] map_idx;
   logic [GROUP-1:0][PW-1:0]    slot;

   rnm_slot_alloc #(
      .GROUP    (GROUP),
      .NUM_PHYS (NUM_PHYS),
      .PW       (PW)
   ) u_alloc (
      .vld_i  (grp_vld_i),
      .base_i (slot_base_i),
      .slot_o (slot)
   );

   rnm_lookup #(
      .NUM_ARCH (NUM_ARCH),
      .GROUP    (GROUP),
      .AW       (AW),
      .PW       (PW)
   ) u_lookup (
      .map_rob_i   (map_rob),
      .map_idx_i   (map_idx),
      .vld_i       (grp_vld_i),
      .src_a_i     (grp_src_a_i),
      .src_b_i     (grp_src_b_i),
      .dst_i       (grp_dst_i),
      .slot_i      (slot),
      .src_a_rob_o (src_a_rob_o),
      .src_a_idx_o (src_a_idx_o),
      .src_b_rob_o (src_b_rob_o),
      .src_b_idx_o (src_b_idx_o)
   );

   rnm_map #(
      .NUM_ARCH  (NUM_ARCH),
      .GROUP     (GROUP),
      .RET_PORTS (RET_PORTS),
      .AW        (AW),
      .PW        (PW)
   ) u_map (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .vld_i      (grp_vld_i),
      .dst_i      (grp_dst_i),
      .slot_i     (slot),
      .ret_vld_i  (ret_vld_i),
      .ret_reg_i  (ret_reg_i),
      .ret_slot_i (ret_slot_i),
      .map_rob_o  (map_rob),
      .map_idx_o  (map_idx)
   );

   assign dst_slot_o = slot;
endmodule

// File: rtl/rnm_rename_chk.sv
module rnm_rename_chk #(
   parameter int  NUM_ARCH = 8,
   parameter int  NUM_PHYS = 40,
   parameter int  GROUP    = 4,
   localparam int AW       = $clog2(NUM_ARCH),
   localparam int PW       = $clog2(NUM_PHYS)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     flush_i,
   input logic [GROUP-1:0]         grp_vld_i,
   input logic [GROUP-1:0][AW-1:0] grp_src_a_i,
   input logic [GROUP-1:0][AW-1:0] grp_dst_i,
   input logic [PW-1:0]            slot_base_i,
   input logic [GROUP-1:0]         src_a_rob_o,
   input logic [GROUP-1:0][PW-1:0] src_a_idx_o,
   input logic [GROUP-1:0][PW-1:0] dst_slot_o
);
   logic unused_chk;
   assign unused_chk = ^{grp_src_a_i, grp_dst_i, src_a_rob_o, src_a_idx_o};

   // R3
   slot_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_vld_i[0] |-> (dst_slot_o[0] == slot_base_i));

   for (genvar k = 0; k < GROUP; k++) begin : g_range
      // R3
      slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         grp_vld_i[k] |-> (int'(dst_slot_o[k]) < NUM_PHYS));
   end

   // R4
   chain_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(grp_vld_i) == GROUP'(1)) && !$past(flush_i) && grp_vld_i[0] &&
       (grp_src_a_i[0] == $past(grp_dst_i[0])))
      |-> (src_a_rob_o[0] && (src_a_idx_o[0] == $past(dst_slot_o[0]))));

   // R8
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush_i) && grp_vld_i[0])
      |-> (!src_a_rob_o[0] && (src_a_idx_o[0] == PW'(grp_src_a_i[0]))));

   if (GROUP > 1) begin : g_pair
      // R5
      lane_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_vld_i[0] && grp_vld_i[1] && (grp_src_a_i[1] == grp_dst_i[0]))
         |-> (src_a_rob_o[1] && (src_a_idx_o[1] == dst_slot_o[0])));

      // R3
      slot_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_vld_i[0] && grp_vld_i[1]) |-> (dst_slot_o[1] != dst_slot_o[0]));
   end
endmodule

bind rnm_rename rnm_rename_chk #(
   .NUM_ARCH (NUM_ARCH),
   .NUM_PHYS (NUM_PHYS),
   .GROUP    (GROUP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush_i     (flush_i),
   .grp_vld_i   (grp_vld_i),
   .grp_src_a_i (grp_src_a_i),
   .grp_dst_i   (grp_dst_i),
   .slot_base_i (slot_base_i),
   .src_a_rob_o (src_a_rob_o),
   .src_a_idx_o (src_a_idx_o),
   .dst_slot_o  (dst_slot_o)
);

// File: tb/rnm_rename_tb.sv
module rnm_rename_tb;
   localparam int G  = 4;
   localparam int RP = 2;
   localparam int AW = 3;
   localparam int PW = 6;
   localparam int NV = 14;

   typedef struct packed {
      logic [3:0]      vld;
      logic [3:0][2:0] sa;
      logic [3:0][2:0] dst;
      logic [5:0]      base;
      logic            rv;
      logic [2:0]      ra;
      logic [5:0]      rk;
      logic            fl;
      logic [3:0][6:0] ea;   // {flag, index} expected per lane
      logic [3:0][5:0] ed;   // expected slot per lane
      logic [7:0]      req;
   } vec_t;

   // flag 0 = committed file, 1 = reorder slot; sources b driven equal to a
   localparam vec_t VECS [NV] = '{
      // R1: first rename after reset reads the committed file
      '{4'b0001, {3'd0,3'd0,3'd0,3'd3}, {3'd0,3'd0,3'd0,3'd1}, 6'd0, 1'b0, 3'd0, 6'd0, 1'b0,
        {7'd0,7'd0,7'd0,{1'b0,6'd3}}, {6'd0,6'd0,6'd0,6'd0}, 8'd1},
      // R5: lane 1 picks up lane 0's fresh slot
      '{4'b0011, {3'd0,3'd0,3'd1,3'd1}, {3'd0,3'd0,3'd2,3'd1}, 6'd1, 1'b0, 3'd0, 6'd0, 1'b0,
        {7'd0,7'd0,{1'b1,6'd1},{1'b1,6'd0}}, {6'd0,6'd0,6'd2,6'd1}, 8'd5},
      // R5: two writers of r5, readers take the higher lane
      '{4'b1111, {3'd5,3'd5,3'd2,3'd2}, {3'd4,3'd3,3'd5,3'd5}, 6'd3, 1'b0, 3'd0, 6'd0, 1'b0,
        {{1'b1,6'd4},{1'b1,6'd4},{1'b1,6'd2},{1'b1,6'd2}}, {6'd6,6'd5,6'd4,6'd3}, 8'd5},
      // R4: map kept the higher lane's slot
      '{4'b0001, {3'd0,3'd0,3'd0,3'd5}, {3'd0,3'd0,3'd0,3'd0}, 6'd7, 1'b0, 3'd0, 6'd0, 1'b0,
        {7'd0,7'd0,7'd0,{1'b1,6'd4}}, {6'd0,6'd0,6'd0,6'd7}, 8'd4},
      // R9: lanes 0 and 2 invalid, no slot, no bypass
      '{4'b1010, {3'd6,3'd0,3'd0,3'd0}, {3'd7,3'd6,3'd6,3'd0}, 6'd8, 1'b0, 3'd0, 6'd0, 1'b0,
        {{1'b1,6'd8},7'd0,{1'b1,6'd7},7'd0}, {6'd9,6'd0,6'd8,6'd0}, 8'd9},
      // R2: same-cycle matching retire not yet visible
      '{4'b0001, {3'd0,3'd0,3'd0,3'd1}, {3'd0,3'd0,3'd0,3'd2}, 6'd10, 1'b1, 3'd1, 6'd1, 1'b0,
        {7'd0,7'd0,7'd0,{1'b1,6'd1}}, {6'd0,6'd0,6'd0,6'd10}, 8'd2},
      // R6: r1 cleared; stale retire of r5 slot 3 issued here
      '{4'b0011, {3'd0,3'd0,3'd2,3'd1}, {3'd0,3'd0,3'd4,3'd3}, 6'd11, 1'b1, 3'd5, 6'd3, 1'b0,
        {7'd0,7'd0,{1'b1,6'd10},{1'b0,6'd1}}, {6'd0,6'd0,6'd12,6'd11}, 8'd6},
      // R6: stale retire left r5; retire r0 slot 7 collides with rename of r0
      '{4'b0001, {3'd0,3'd0,3'd0,3'd5}, {3'd0,3'd0,3'd0,3'd0}, 6'd13, 1'b1, 3'd0, 6'd7, 1'b0,
        {7'd0,7'd0,7'd0,{1'b1,6'd4}}, {6'd0,6'd0,6'd0,6'd13}, 8'd6},
      // R7: rename beat the retire
      '{4'b0001, {3'd0,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd1}, 6'd38, 1'b0, 3'd0, 6'd0, 1'b0,
        {7'd0,7'd0,7'd0,{1'b1,6'd13}}, {6'd0,6'd0,6'd0,6'd38}, 8'd7},
      // R3: slots wrap 39 -> 0 -> 1
      '{4'b0111, {3'd0,3'd3,3'd2,3'd1}, {3'd0,3'd4,3'd3,3'd2}, 6'd39, 1'b0, 3'd0, 6'd0, 1'b0,
        {7'd0,{1'b1,6'd0},{1'b1,6'd39},{1'b1,6'd38}}, {6'd0,6'd1,6'd0,6'd39}, 8'd3},
      // R8: flush cycle, lookup still old
      '{4'b0001, {3'd0,3'd0,3'd0,3'd4}, {3'd0,3'd0,3'd0,3'd5}, 6'd2, 1'b0, 3'd0, 6'd0, 1'b1,
        {7'd0,7'd0,7'd0,{1'b1,6'd1}}, {6'd0,6'd0,6'd0,6'd2}, 8'd8},
      // R8: all committed, flush-cycle rename dropped
      '{4'b0011, {3'd0,3'd0,3'd7,3'd5}, {3'd0,3'd0,3'd7,3'd6}, 6'd0, 1'b0, 3'd0, 6'd0, 1'b0,
        {7'd0,7'd0,{1'b0,6'd7},{1'b0,6'd5}}, {6'd0,6'd0,6'd1,6'd0}, 8'd8},
      // R9: empty group naming r6
      '{4'b0000, {3'd0,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd6}, 6'd5, 1'b0, 3'd0, 6'd0, 1'b0,
        {7'd0,7'd0,7'd0,7'd0}, {6'd0,6'd0,6'd0,6'd0}, 8'd9},
      // R9: r6 untouched by the empty group
      '{4'b0001, {3'd0,3'd0,3'd0,3'd6}, {3'd0,3'd0,3'd0,3'd0}, 6'd2, 1'b0, 3'd0, 6'd0, 1'b0,
        {7'd0,7'd0,7'd0,{1'b1,6'd0}}, {6'd0,6'd0,6'd0,6'd2}, 8'd9}
   };

   logic                     clk;
   logic                     rst_n;
   logic                     flush_i;
   logic [G-1:0]             grp_vld_i;
   logic [G-1:0][AW-1:0]     grp_src_a_i;
   logic [G-1:0][AW-1:0]     grp_src_b_i;
   logic [G-1:0][AW-1:0]     grp_dst_i;
   logic [PW-1:0]            slot_base_i;
   logic [RP-1:0]            ret_vld_i;
   logic [RP-1:0][AW-1:0]    ret_reg_i;
   logic [RP-1:0][PW-1:0]    ret_slot_i;
   logic [G-1:0]             src_a_rob_o;
   logic [G-1:0][PW-1:0]     src_a_idx_o;
   logic [G-1:0]             src_b_rob_o;
   logic [G-1:0][PW-1:0]     src_b_idx_o;
   logic [G-1:0][PW-1:0]     dst_slot_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   rnm_rename u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (flush_i),
      .grp_vld_i   (grp_vld_i),
      .grp_src_a_i (grp_src_a_i),
      .grp_src_b_i (grp_src_b_i),
      .grp_dst_i   (grp_dst_i),
      .slot_base_i (slot_base_i),
      .ret_vld_i   (ret_vld_i),
      .ret_reg_i   (ret_reg_i),
      .ret_slot_i  (ret_slot_i),
      .src_a_rob_o (src_a_rob_o),
      .src_a_idx_o (src_a_idx_o),
      .src_b_rob_o (src_b_rob_o),
      .src_b_idx_o (src_b_idx_o),
      .dst_slot_o  (dst_slot_o)
   );

   // 250 MHz
   initial begin
      clk = 1'b0;
      forever #2 clk = ~clk;
   end

   task automatic check(input string what, input int req, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s got=%0h exp=%0h", req, what, got, exp);
      end
   endtask

   task automatic idle();
      flush_i     = 1'b0;
      grp_vld_i   = '0;
      grp_src_a_i = '0;
      grp_src_b_i = '0;
      grp_dst_i   = '0;
      slot_base_i = '0;
      ret_vld_i   = '0;
      ret_reg_i   = '0;
      ret_slot_i  = '0;
   endtask

   task automatic apply(input vec_t t);
      grp_vld_i     = t.vld;
      grp_src_a_i   = t.sa;
      grp_src_b_i   = t.sa;
      grp_dst_i     = t.dst;
      slot_base_i   = t.base;
      ret_vld_i     = {1'b0, t.rv};
      ret_reg_i     = '0;
      ret_slot_i    = '0;
      ret_reg_i[0]  = t.ra;
      ret_slot_i[0] = t.rk;
      flush_i       = t.fl;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired before the run ended");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      idle();
      repeat (3) @(negedge clk);
      // R1: all lanes during reset read the committed file
      grp_vld_i   = 4'b1111;
      grp_src_a_i = {3'd3, 3'd2, 3'd1, 3'd0};
      grp_src_b_i = {3'd7, 3'd6, 3'd5, 3'd4};
      grp_dst_i   = '0;
      #1;
      for (int l = 0; l < G; l++) begin
         check("reset src a", 1, int'({src_a_rob_o[l], src_a_idx_o[l]}), l);
         check("reset src b", 1, int'({src_b_rob_o[l], src_b_idx_o[l]}), l + 4);
      end
      @(negedge clk);
      idle();
      rst_n = 1'b1;

      // table walk: drive at falling edge, sample 1 ns later, map updates at rising edge
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         apply(VECS[v]);
         #1;
         for (int l = 0; l < G; l++) begin
            if (VECS[v].vld[l]) begin
               check($sformatf("vec%0d lane%0d src a", v, l), int'(VECS[v].req),
                     int'({src_a_rob_o[l], src_a_idx_o[l]}), int'(VECS[v].ea[l]));
               check($sformatf("vec%0d lane%0d src b", v, l), int'(VECS[v].req),
                     int'({src_b_rob_o[l], src_b_idx_o[l]}), int'(VECS[v].ea[l]));
               check($sformatf("vec%0d lane%0d slot", v, l), int'(VECS[v].req),
                     int'(dst_slot_o[l]), int'(VECS[v].ed[l]));
            end
         end
      end

      // R6 on the second retire port: r7 holds slot 1 and is cleared
      @(negedge clk);
      idle();
      ret_vld_i     = 2'b10;
      ret_reg_i[1]  = 3'd7;
      ret_slot_i[1] = 6'd1;
      @(negedge clk);
      idle();
      grp_vld_i      = 4'b0001;
      grp_src_a_i[0] = 3'd7;
      grp_src_b_i[0] = 3'd6;
      #1;
      check("port1 retire cleared r7", 6, int'({src_a_rob_o[0], src_a_idx_o[0]}), 7);
      check("r6 still in slot 0", 6, int'({src_b_rob_o[0], src_b_idx_o[0]}), 64);

      @(negedge clk);
      idle();
      finish_run();
   end
endmodule